// File: doc/BRIEF.md
# Register Window Trap Controller

This block tracks the current window pointer of a processor whose register file is split into a power-of-two number of overlapping windows, and sequences the two control-flow events that move it: taking a trap and returning from one. When a trap is accepted, the pointer steps back one window. The block then issues write strobes that store the interrupted program counter pair into two local registers of the new window, builds the vector register from a fixed base and the trap code, and redirects fetch to that vector. It also updates the supervisor, previous-supervisor and trap-enable flags.

On a return, the block proposes the next window up and tests that index against the window-invalid mask. If the window is free, the return completes and the privilege flags are restored. If the window is marked invalid, the pointer stays where it is and the block starts an underflow trap on its own in the next cycle, using the program counters that were presented with the return. A trap that arrives while traps are disabled does not vector. It puts the block into a sticky error state. The register storage itself lives outside this block.

Top module: `trap_window_ctrl`

## Requirements
- R1: After reset: window pointer = `CWP_RST` (0); supervisor = 1; previous-supervisor = 0; trap-enable = 1; error = 0; busy = 0; redirect = 0; both save strobes = 0; vector register = `TBR_BASE`; PC and nPC outputs = 0.
- R2: An accepted trap with trap-enable set moves the window pointer to (pointer − 1) modulo `NWIN`, so window 0 wraps to `NWIN`−1. The result is visible after the accepting clock edge.
- R3: Trap entry raises both save strobes for exactly one cycle. The first save register carries the PC and the second carries the nPC sampled at the accepting edge. The target window is the new pointer value.
- R4: Trap entry sets the vector register to `TBR_BASE` with bits 11:4 replaced by the 8-bit trap code.
- R5: Trap entry raises a one-cycle redirect, drives the PC output with the new vector value, and drives the nPC output with that value plus 4.
- R6: Trap entry copies the supervisor flag into the previous-supervisor flag, sets supervisor to 1 and clears trap-enable.
- R7: A trap request while trap-enable is 0 sets the error flag and changes no other state. Once the error flag is set, it stays set until reset and all later requests are ignored.
- R8: A return whose candidate window (pointer + 1 modulo `NWIN`) has its mask bit clear moves the pointer to the candidate, copies previous-supervisor into supervisor, and sets trap-enable. It raises no redirect and no save strobe.
- R9: A return whose candidate window has its mask bit set leaves the pointer unchanged. At the next edge, a trap entry with code 0x06 follows whatever the trap-enable value is. That entry saves the PC and nPC captured with the return, and it ignores any request present in that cycle.
- R10: Busy is high for exactly one cycle after each accepted operation. Requests presented while busy is high are ignored.
- R11: When a trap request and a return request arrive in the same cycle, only the trap is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Request to take a trap this cycle |
| trap_code | input | 8 | Trap type for the request |
| ret_req | input | 1 | Request to return from trap this cycle |
| pc_in | input | XLEN | Current program counter |
| npc_in | input | XLEN | Current next program counter |
| wim_in | input | NWIN | Window-invalid mask, bit i marks window i |
| cwp_o | output | CW | Current window pointer |
| save_pc_we | output | 1 | Write strobe for the saved-PC local register of window `cwp_o` |
| save_npc_we | output | 1 | Write strobe for the saved-nPC local register of window `cwp_o` |
| save_pc_o | output | XLEN | Data for the saved-PC register |
| save_npc_o | output | XLEN | Data for the saved-nPC register |
| redirect_o | output | 1 | One-cycle fetch redirect |
| pc_o | output | XLEN | New program counter |
| npc_o | output | XLEN | New next program counter |
| tbr_o | output | XLEN | Vector register |
| sup_o | output | 1 | Supervisor flag |
| prev_sup_o | output | 1 | Previous-supervisor flag |
| et_o | output | 1 | Trap-enable flag |
| err_o | output | 1 | Error state |
| busy_o | output | 1 | Operation in progress |

## Verification
The hardest situation to reach is the self-generated underflow trap. The stimulus first has to be in a state where a return is legal, then present a mask with the candidate window's bit set. It must also put a competing trap request on the exact cycle in which the internal underflow entry runs. The stimulus does this by wrapping the pointer through window 0, setting the single mask bit of the next window, and driving a trap request in the following cycle. The scoreboard then expects code 0x06, the return's saved program counters and a wrapped pointer, with no effect from the competing request.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam logic [7:0] TT_WIN_UNDERFLOW = 8'h06;
    localparam int         VEC_SHIFT        = 4;
    localparam int         NPC_STEP         = 4;
endpackage

// File: rtl/twc_window_step.sv
module twc_window_step #(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic [CW-1:0]   cwp,
    input  logic [NWIN-1:0] wim,
    output logic [CW-1:0]   cwp_dec,
    output logic [CW-1:0]   cwp_inc,
    output logic            inc_blocked
);
    localparam int SPAN = 1 << CW;

    generate
        if (SPAN == NWIN) begin : g_wrap_natural
            assign cwp_dec = cwp - 1'b1;
            assign cwp_inc = cwp + 1'b1;
        end else begin : g_wrap_compare
            assign cwp_dec = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
            assign cwp_inc = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
        end
    endgenerate

    assign inc_blocked = wim[cwp_inc];
endmodule

// File: rtl/twc_vector.sv
module twc_vector #(
    parameter int              XLEN     = 32,
    parameter int              TTW      = 8,
    parameter logic [XLEN-1:0] TBR_BASE = 32'h4000_0000
) (
    input  logic [TTW-1:0]  tt,
    output logic [XLEN-1:0] tbr_new,
    output logic [XLEN-1:0] npc_new
);
    import twc_pkg::*;
    localparam logic [XLEN-1:0] TT_MASK = XLEN'(((1 << TTW) - 1) << VEC_SHIFT);

    assign tbr_new = (TBR_BASE & ~TT_MASK) | (XLEN'(tt) << VEC_SHIFT);
    assign npc_new = tbr_new + XLEN'(NPC_STEP);
endmodule

// File: rtl/trap_window_ctrl.sv
module trap_window_ctrl #(
    parameter int              NWIN     = 8,
    parameter int              XLEN     = 32,
    parameter int              CWP_RST  = 0,
    parameter logic [XLEN-1:0] TBR_BASE = 32'h4000_0000,
    localparam int             CW       = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [7:0]      trap_code,
    input  logic            ret_req,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] npc_in,
    input  logic [NWIN-1:0] wim_in,
    output logic [CW-1:0]   cwp_o,
    output logic            save_pc_we,
    output logic            save_npc_we,
    output logic [XLEN-1:0] save_pc_o,
    output logic [XLEN-1:0] save_npc_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] npc_o,
    output logic [XLEN-1:0] tbr_o,
    output logic            sup_o,
    output logic            prev_sup_o,
    output logic            et_o,
    output logic            err_o,
    output logic            busy_o
);
    import twc_pkg::*;

    typedef struct packed {
        logic [CW-1:0]   cwp;
        logic            sup;
        logic            psup;
        logic            et;
        logic            err;
        logic            busy;
        logic            pend;
        logic            redir;
        logic            we;
        logic [XLEN-1:0] hold_pc;
        logic [XLEN-1:0] hold_npc;
        logic [XLEN-1:0] sv_pc;
        logic [XLEN-1:0] sv_npc;
        logic [XLEN-1:0] tbr;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
    } state_t;

    state_t st_d, st_q;

    logic [CW-1:0]   cwp_dec_w, cwp_inc_w;
    logic            ret_blocked_w;
    logic [7:0]      tt_sel_w;
    logic [XLEN-1:0] tbr_new_w, npc_new_w;
    logic [XLEN-1:0] src_pc_w, src_npc_w;
    logic            take_trap_w;

    twc_window_step #(.NWIN(NWIN), .CW(CW)) u_step (
        .cwp         (st_q.cwp),
        .wim         (wim_in),
        .cwp_dec     (cwp_dec_w),
        .cwp_inc     (cwp_inc_w),
        .inc_blocked (ret_blocked_w)
    );

    assign tt_sel_w  = st_q.pend ? TT_WIN_UNDERFLOW : trap_code;
    assign src_pc_w  = st_q.pend ? st_q.hold_pc  : pc_in;
    assign src_npc_w = st_q.pend ? st_q.hold_npc : npc_in;

    twc_vector #(.XLEN(XLEN), .TTW(8), .TBR_BASE(TBR_BASE)) u_vec (
        .tt      (tt_sel_w),
        .tbr_new (tbr_new_w),
        .npc_new (npc_new_w)
    );

    // Trap entry happens for a pending underflow, or a fresh trap with traps enabled
    always_comb begin
        take_trap_w = 1'b0;
        if (!st_q.err) begin
            if (st_q.pend)
                take_trap_w = 1'b1;
            else if (!st_q.busy && trap_req && st_q.et)
                take_trap_w = 1'b1;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.busy  = 1'b0;
        st_d.redir = 1'b0;
        st_d.we    = 1'b0;
        st_d.pend  = 1'b0;
        if (!st_q.err && !st_q.pend && !st_q.busy) begin
            if (trap_req) begin
                if (!st_q.et) begin
                    st_d.err  = 1'b1;
                    st_d.busy = 1'b1;
                end
            end else if (ret_req) begin
                st_d.busy = 1'b1;
                if (ret_blocked_w) begin
                    st_d.pend     = 1'b1;
                    st_d.hold_pc  = pc_in;
                    st_d.hold_npc = npc_in;
                end else begin
                    st_d.cwp = cwp_inc_w;
                    st_d.sup = st_q.psup;
                    st_d.et  = 1'b1;
                end
            end
        end
        if (take_trap_w) begin
            st_d.cwp    = cwp_dec_w;
            st_d.we     = 1'b1;
            st_d.sv_pc  = src_pc_w;
            st_d.sv_npc = src_npc_w;
            st_d.tbr    = tbr_new_w;
            st_d.pc     = tbr_new_w;
            st_d.npc    = npc_new_w;
            st_d.redir  = 1'b1;
            st_d.psup   = st_q.sup;
            st_d.sup    = 1'b1;
            st_d.et     = 1'b0;
            st_d.busy   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cwp <= CW'(CWP_RST);
            st_q.sup <= 1'b1;
            st_q.et  <= 1'b1;
            st_q.tbr <= TBR_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp_o       = st_q.cwp;
    assign save_pc_we  = st_q.we;
    assign save_npc_we = st_q.we;
    assign save_pc_o   = st_q.sv_pc;
    assign save_npc_o  = st_q.sv_npc;
    assign redirect_o  = st_q.redir;
    assign pc_o        = st_q.pc;
    assign npc_o       = st_q.npc;
    assign tbr_o       = st_q.tbr;
    assign sup_o       = st_q.sup;
    assign prev_sup_o  = st_q.psup;
    assign et_o        = st_q.et;
    assign err_o       = st_q.err;
    assign busy_o      = st_q.busy;

    assert_cwp_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (cwp_o == CW'($past(cwp_o) - 1'b1)));

    assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (pc_o == tbr_o && npc_o == tbr_o + XLEN'(NPC_STEP)));

    assert_entry_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (!et_o && sup_o));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o && $stable(cwp_o) && !redirect_o));

    assert_underflow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> (cwp_o == $past(cwp_o)));

    assert_underflow_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> (redirect_o && tbr_o[11:4] == TT_WIN_UNDERFLOW));

    assert_busy_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !st_q.pend) |=> !busy_o);
endmodule

// File: tb/trap_window_ctrl_bench.sv
module trap_window_ctrl_bench;
    localparam int          PERIOD = 10;
    localparam int          NWIN   = 8;
    localparam int          XLEN   = 32;
    localparam int          CW     = 3;
    localparam logic [31:0] BASE   = 32'h4000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0;
    logic [7:0]      trap_code = '0;
    logic            ret_req = 1'b0;
    logic [XLEN-1:0] pc_in = '0;
    logic [XLEN-1:0] npc_in = '0;
    logic [NWIN-1:0] wim_in = '0;
    logic [CW-1:0]   cwp_o;
    logic            save_pc_we, save_npc_we, redirect_o, sup_o, prev_sup_o, et_o, err_o, busy_o;
    logic [XLEN-1:0] save_pc_o, save_npc_o, pc_o, npc_o, tbr_o;

    always #(PERIOD/2) clk = ~clk;

    trap_window_ctrl #(.NWIN(NWIN), .XLEN(XLEN), .CWP_RST(0), .TBR_BASE(BASE)) u_trap_window_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_code(trap_code),
        .ret_req(ret_req), .pc_in(pc_in), .npc_in(npc_in), .wim_in(wim_in),
        .cwp_o(cwp_o), .save_pc_we(save_pc_we), .save_npc_we(save_npc_we),
        .save_pc_o(save_pc_o), .save_npc_o(save_npc_o), .redirect_o(redirect_o),
        .pc_o(pc_o), .npc_o(npc_o), .tbr_o(tbr_o), .sup_o(sup_o),
        .prev_sup_o(prev_sup_o), .et_o(et_o), .err_o(err_o), .busy_o(busy_o)
    );

    typedef struct packed {
        logic [CW-1:0] cwp;
        logic sup, psup, et, err, busy, redir, we;
        logic [31:0] svpc, svnpc, tbr, pc, npc;
    } snap_t;

    snap_t       exp_q[$];
    snap_t       m;
    logic        m_pend = 1'b0;
    logic [31:0] m_hpc = '0, m_hnpc = '0;
    int          n_chk = 0;
    int          n_err = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_entry(input logic [7:0] tt, input logic [31:0] p, input logic [31:0] np);
        m.cwp   = m.cwp - 1'b1;
        m.we    = 1'b1;
        m.svpc  = p;
        m.svnpc = np;
        m.tbr   = {BASE[31:12], tt, 4'h0};
        m.pc    = m.tbr;
        m.npc   = m.tbr + 32'd4;
        m.redir = 1'b1;
        m.psup  = m.sup;
        m.sup   = 1'b1;
        m.et    = 1'b0;
        m.busy  = 1'b1;
    endtask

    // Driver: one call per clock; pushes the expected state after the next edge
    task automatic step(input logic t, input logic [7:0] tt, input logic r,
                        input logic [31:0] p, input logic [31:0] np, input logic [7:0] w);
        logic pend_now;
        logic busy_now;
        logic [CW-1:0] cand;
        @(negedge clk);
        trap_req = t; trap_code = tt; ret_req = r; pc_in = p; npc_in = np; wim_in = w;
        pend_now = m_pend;
        busy_now = m.busy;
        m.busy = 1'b0; m.redir = 1'b0; m.we = 1'b0; m_pend = 1'b0;
        if (!m.err) begin
            if (pend_now) begin
                model_entry(8'h06, m_hpc, m_hnpc);
            end else if (!busy_now) begin
                if (t) begin
                    if (m.et) model_entry(tt, p, np);
                    else begin m.err = 1'b1; m.busy = 1'b1; end
                end else if (r) begin
                    cand = m.cwp + 1'b1;
                    m.busy = 1'b1;
                    if (w[cand]) begin
                        m_pend = 1'b1; m_hpc = p; m_hnpc = np;
                    end else begin
                        m.cwp = cand; m.sup = m.psup; m.et = 1'b1;
                    end
                end
            end
        end
        exp_q.push_back(m);
    endtask

    // Monitor: compares after each edge
    initial begin
        snap_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk("R2/R8", "cwp", 32'(cwp_o), 32'(e.cwp));
                chk("R3", "save_pc_we", 32'(save_pc_we), 32'(e.we));
                chk("R3", "save_npc_we", 32'(save_npc_we), 32'(e.we));
                chk("R3", "save_pc", save_pc_o, e.svpc);
                chk("R3", "save_npc", save_npc_o, e.svnpc);
                chk("R4", "tbr", tbr_o, e.tbr);
                chk("R5", "redirect", 32'(redirect_o), 32'(e.redir));
                chk("R5", "pc", pc_o, e.pc);
                chk("R5", "npc", npc_o, e.npc);
                chk("R6/R8", "sup", 32'(sup_o), 32'(e.sup));
                chk("R6", "prev_sup", 32'(prev_sup_o), 32'(e.psup));
                chk("R6/R8", "et", 32'(et_o), 32'(e.et));
                chk("R7", "err", 32'(err_o), 32'(e.err));
                chk("R10", "busy", 32'(busy_o), 32'(e.busy));
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        m = '0; m.sup = 1'b1; m.et = 1'b1; m.tbr = BASE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "cwp", 32'(cwp_o), 32'd0);
        chk("R1", "sup", 32'(sup_o), 32'd1);
        chk("R1", "prev_sup", 32'(prev_sup_o), 32'd0);
        chk("R1", "et", 32'(et_o), 32'd1);
        chk("R1", "err", 32'(err_o), 32'd0);
        chk("R1", "busy", 32'(busy_o), 32'd0);
        chk("R1", "redirect", 32'(redirect_o), 32'd0);
        chk("R1", "save_we", 32'(save_pc_we | save_npc_we), 32'd0);
        chk("R1", "tbr", tbr_o, BASE);
        chk("R1", "pc", pc_o, 32'd0);
        // R8: plain return from reset, sup <- prev_sup (0)
        step(0, 8'h00, 1, 32'h0000_0500, 32'h0000_0504, 8'h00);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        // R2..R6: trap from window 1
        step(1, 8'h2A, 0, 32'h0000_1000, 32'h0000_1004, 8'h00);
        // R10: request while busy is ignored
        step(1, 8'h33, 0, 32'h0000_1100, 32'h0000_1104, 8'h00);
        step(0, 8'h00, 1, 32'h0000_1200, 32'h0000_1204, 8'h00);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        // R11: trap and return together, trap wins
        step(1, 8'h05, 1, 32'h0000_1300, 32'h0000_1304, 8'h00);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        // R9: return into an invalid window (candidate 1), then competing trap during entry
        step(0, 8'h00, 1, 32'h0000_2000, 32'h0000_2004, 8'h02);
        step(1, 8'h77, 0, 32'h0000_2100, 32'h0000_2104, 8'h02);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        // R8: return wrapping 7 -> 0
        step(0, 8'h00, 1, 32'h0000_3000, 32'h0000_3004, 8'h00);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        // R2/R4: wrap 0 -> 7, full trap code
        step(1, 8'hFF, 0, 32'h0000_4000, 32'h0000_4004, 8'h00);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        // R7: trap with traps disabled, then everything ignored
        step(1, 8'h12, 0, 32'h0000_5000, 32'h0000_5004, 8'h00);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        step(0, 8'h00, 1, 32'h0000_5100, 32'h0000_5104, 8'h00);
        step(1, 8'h13, 0, 32'h0000_5200, 32'h0000_5204, 8'h00);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule